// File: doc/BRIEF.md
# Angular rate threshold detector

This block watches three signed angular-rate channels and raises an event when the magnitude on any enabled axis stays above a programmable limit for a programmable number of sample periods. A sample strobe marks each new X/Y/Z triple. Per axis, the magnitude is reduced to its upper bits and compared with a 7-bit limit. A debounce counter then decides whether the axis is in the event state. While the rate is below the limit, the counter either clears or steps down, depending on a mode bit.

The result is a source byte and an interrupt flag. The source byte gives an event bit and a sign bit for each axis, plus a summary bit. The event bits can either latch until the source byte is read or follow the debounced state of the most recent sample. Reading the source byte drops the interrupt. A pulse marking entry into run mode wipes all detector state so that a new run starts clean.

Top module: `rate_thresh_det`

## Requirements
- R1: After reset, `source` is 0x00 and `rate_irq` is 0.
- R2: On a sample, an axis counts as above the limit only when its enable bit is set and (|rate| >> 8) is strictly greater than `limit_cfg[6:0]`. |rate| is the full magnitude, so -32768 gives 32768.
- R3: Each sample above the limit increments that axis's counter. The axis hits on the sample where the counter equals `debounce_len`, so a length of 0 hits on the first sample above the limit.
- R4: When `limit_cfg[7]` is 1, a sample below the limit clears the counter to zero.
- R5: When `limit_cfg[7]` is 0, a sample below the limit lowers the counter by one, and the counter never goes below zero.
- R6: The counter saturates at `debounce_len`. While saturated, every sample above the limit is a hit.
- R7: `axis_cfg` bits 0, 1 and 2 enable X, Y and Z. A disabled axis never hits.
- R8: Layout of `source`: bit 0 is X sign and bit 1 is X event; bit 2 is Y sign and bit 3 is Y event; bit 4 is Z sign and bit 5 is Z event; bit 6 is the OR of the event bits; bit 7 is 0. A sign bit is 1 when the hitting rate was negative, and it reads 0 whenever its event bit is 0.
- R9: When `axis_cfg[3]` is 1, an event bit sets on a hit and holds until `source_rd`. If a hit and a read arrive in the same cycle, the hit wins.
- R10: When `axis_cfg[3]` is 0, the event bits show which axes hit on the most recent sample, and `source_rd` leaves them unchanged.
- R11: `rate_irq` sets on any sample with a hit and clears on `source_rd`. A hit in the same cycle as a read wins.
- R12: A `run_start` pulse clears every counter, event bit, sign bit and `rate_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | New rate triple valid |
| rate_x | input | 16 | Signed X rate |
| rate_y | input | 16 | Signed Y rate |
| rate_z | input | 16 | Signed Z rate |
| axis_cfg | input | 8 | Bits 2:0 axis enables, bit 3 latch enable |
| limit_cfg | input | 8 | Bits 6:0 limit, bit 7 clear-below mode |
| debounce_len | input | 8 | Counts needed to declare an event |
| source_rd | input | 1 | Source byte read strobe |
| run_start | input | 1 | Entering-run pulse, resets detector state |
| source | output | 8 | Event/sign/summary byte |
| rate_irq | output | 1 | Rate event interrupt flag |

## Verification
The bench sets a magnitude exactly equal to the limit next to one step above it, so a design that compares with greater-or-equal raises a false event. It drives more below-limit samples than the counter holds, so a counter that wraps past zero declares an event on the first sample back above the limit. It leaves the counter saturated, drops one sample below, then goes back above, so a counter that keeps climbing past the debounce length never hits again. It also issues a read in the same cycle as a new hit, uses the most negative rate, and pulses run entry in the middle of a debounce: a design with the wrong priority, an overflowing magnitude or leftover state shows an event bit or an interrupt that should be absent.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
    localparam int AXES    = 3;
    localparam int SRC_W   = 8;
    localparam int ANY_BIT = 2 * AXES;

    typedef struct packed {
        logic [AXES-1:0] lat;   // latched event per axis
        logic [AXES-1:0] det;   // hit on most recent sample
        logic [AXES-1:0] pol;   // sign of last hit, 1 = negative
        logic            irq;
    } flag_st_t;
endpackage

// File: rtl/rtd_axis.sv
module rtd_axis #(
    parameter int RATE_W = 16,
    parameter int THR_W  = 7,
    parameter int SHIFT  = 8,
    parameter int CNT_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_stb,
    input  logic                     wipe,
    input  logic                     en,
    input  logic                     clr_mode,
    input  logic signed [RATE_W-1:0] rate,
    input  logic [THR_W-1:0]         limit,
    input  logic [CNT_W-1:0]         need,
    output logic                     hit,
    output logic                     neg
);
    localparam int MAG_W = RATE_W + 1;
    localparam int TOP_W = MAG_W - SHIFT;

    logic [MAG_W-1:0] ext;
    logic [MAG_W-1:0] mag;
    logic [TOP_W-1:0] top;
    logic             above;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        neg   = rate[RATE_W-1];
        ext   = {rate[RATE_W-1], rate};
        mag   = neg ? (~ext + 1'b1) : ext;
        top   = mag[MAG_W-1:SHIFT];
        above = en && (top > TOP_W'(limit));
    end

    always_comb begin
        cnt_d = cnt_q;
        hit   = 1'b0;
        if (wipe) begin
            cnt_d = '0;
        end else if (sample_stb) begin
            if (above) begin
                cnt_d = (cnt_q >= need) ? need : cnt_q + 1'b1;
                hit   = (cnt_d == need);
            end else if (clr_mode) begin
                cnt_d = '0;
            end else if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtd_flags.sv
module rtd_flags
    import rtd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic             sample_stb,
    input  logic             source_rd,
    input  logic             latch_en,
    input  logic [AXES-1:0]  hit,
    input  logic [AXES-1:0]  neg,
    output logic [SRC_W-1:0] source,
    output logic             rate_irq
);
    flag_st_t        st_d, st_q;
    logic [AXES-1:0] vis;

    always_comb begin
        st_d = st_q;
        if (wipe) begin
            st_d = '0;
        end else begin
            if (sample_stb) st_d.det = hit;
            for (int i = 0; i < AXES; i++) begin
                if (hit[i]) begin
                    st_d.pol[i] = neg[i];
                    st_d.lat[i] = 1'b1;
                end else if (source_rd) begin
                    st_d.lat[i] = 1'b0;
                end
            end
            if (|hit)           st_d.irq = 1'b1;
            else if (source_rd) st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        vis    = latch_en ? st_q.lat : st_q.det;
        source = '0;
        for (int i = 0; i < AXES; i++) begin
            source[2*i]   = vis[i] & st_q.pol[i];
            source[2*i+1] = vis[i];
        end
        source[ANY_BIT] = |vis;
        rate_irq        = st_q.irq;
    end
endmodule

// File: rtl/rate_thresh_det.sv
module rate_thresh_det
    import rtd_pkg::*;
#(
    parameter int RATE_W = 16,
    parameter int THR_W  = 7,
    parameter int SHIFT  = 8,
    parameter int CNT_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_stb,
    input  logic signed [RATE_W-1:0] rate_x,
    input  logic signed [RATE_W-1:0] rate_y,
    input  logic signed [RATE_W-1:0] rate_z,
    input  logic [7:0]               axis_cfg,
    input  logic [7:0]               limit_cfg,
    input  logic [CNT_W-1:0]         debounce_len,
    input  logic                     source_rd,
    input  logic                     run_start,
    output logic [SRC_W-1:0]         source,
    output logic                     rate_irq
);
    logic signed [RATE_W-1:0] rates [AXES];
    logic [AXES-1:0]          hit;
    logic [AXES-1:0]          neg;

    assign rates[0] = rate_x;
    assign rates[1] = rate_y;
    assign rates[2] = rate_z;

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        rtd_axis #(
            .RATE_W (RATE_W),
            .THR_W  (THR_W),
            .SHIFT  (SHIFT),
            .CNT_W  (CNT_W)
        ) u_axis (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_stb (sample_stb),
            .wipe       (run_start),
            .en         (axis_cfg[g]),
            .clr_mode   (limit_cfg[7]),
            .rate       (rates[g]),
            .limit      (limit_cfg[THR_W-1:0]),
            .need       (debounce_len),
            .hit        (hit[g]),
            .neg        (neg[g])
        );
    end

    rtd_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .wipe       (run_start),
        .sample_stb (sample_stb),
        .source_rd  (source_rd),
        .latch_en   (axis_cfg[AXES]),
        .hit        (hit),
        .neg        (neg),
        .source     (source),
        .rate_irq   (rate_irq)
    );
endmodule

// File: rtl/rtd_chk.sv
module rtd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sample_stb,
    input logic [7:0] axis_cfg,
    input logic       source_rd,
    input logic       run_start,
    input logic [7:0] source,
    input logic       rate_irq
);
    p_wipe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> (source == 8'h00 && !rate_irq));

    p_read_drops_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (source_rd && !sample_stb) |=> !rate_irq);

    p_irq_from_sample_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rate_irq) |-> $past(sample_stb));

    p_top_bit_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        source[7] == 1'b0);

    p_sign_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!source[1] |-> !source[0]) and (!source[3] |-> !source[2]) and (!source[5] |-> !source[4]));

    p_hold_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (axis_cfg[3] && !sample_stb && !source_rd && !run_start)
        |=> ($stable(source) || !$stable(axis_cfg)));

    p_read_keeps_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!axis_cfg[3] && !sample_stb && !run_start)
        |=> ($stable(source) || !$stable(axis_cfg)));

    p_disabled_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!axis_cfg[3] && !axis_cfg[0] && sample_stb && !run_start)
        |=> (!source[1] || !$stable(axis_cfg)));
endmodule

bind rate_thresh_det rtd_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .axis_cfg   (axis_cfg),
    .source_rd  (source_rd),
    .run_start  (run_start),
    .source     (source),
    .rate_irq   (rate_irq)
);

// File: tb/rate_thresh_det_bench.sv
`timescale 1ns/1ps
module rate_thresh_det_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sample_stb = 1'b0;
    logic signed [15:0] rate_x = '0, rate_y = '0, rate_z = '0;
    logic [7:0]         axis_cfg = '0, limit_cfg = '0, debounce_len = '0;
    logic               source_rd = 1'b0, run_start = 1'b0;
    logic [7:0]         source;
    logic               rate_irq;
    int                 n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    rate_thresh_det u_rate_thresh_det (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .rate_x(rate_x), .rate_y(rate_y), .rate_z(rate_z),
        .axis_cfg(axis_cfg), .limit_cfg(limit_cfg), .debounce_len(debounce_len),
        .source_rd(source_rd), .run_start(run_start),
        .source(source), .rate_irq(rate_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic smp(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
        @(negedge clk);
        rate_x = x; rate_y = y; rate_z = z; sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); source_rd = 1'b1;
        @(negedge clk); source_rd = 1'b0;
    endtask

    task automatic start(input logic [7:0] c, input logic [7:0] l, input logic [7:0] d);
        @(negedge clk);
        axis_cfg = c; limit_cfg = l; debounce_len = d; run_start = 1'b1;
        @(negedge clk); run_start = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 source", source, 8'h00);
        check("R1 irq", {7'b0, rate_irq}, 8'h00);
    endtask

    task automatic t_limit();
        start(8'h0F, 8'h85, 8'd0);
        smp(16'h0500, 16'h0000, 16'h0000);
        check("R2 equal not above", source, 8'h00);
        smp(16'h0600, 16'h0000, 16'h0000);
        check("R2 one above", source, 8'h42);
        check("R11 irq on hit", {7'b0, rate_irq}, 8'h01);
        rd();
        check("R9 read clears", source, 8'h00);
        check("R11 read clears irq", {7'b0, rate_irq}, 8'h00);
        smp(16'hFA00, 16'h0000, 16'h0000);
        check("R8 negative X", source, 8'h43);
        rd();
        smp(16'h0000, 16'h8000, 16'h7FFF);
        check("R8 Y min neg and Z pos", source, 8'h6C);
        rd();
    endtask

    task automatic t_clear_mode();
        start(8'h09, 8'h85, 8'd3);
        smp(16'h0700, 0, 0); smp(16'h0700, 0, 0);
        check("R3 two of three", source, 8'h00);
        smp(16'h0700, 0, 0);
        check("R3 third sample", source, 8'h42);
        rd();
        smp(16'h0100, 0, 0);
        smp(16'h0700, 0, 0); smp(16'h0700, 0, 0);
        check("R4 cleared counter", source, 8'h00);
        smp(16'h0700, 0, 0);
        check("R4 recount", source, 8'h42);
        rd();
    endtask

    task automatic t_dec_mode();
        start(8'h09, 8'h05, 8'd3);
        for (int i = 0; i < 8; i++) smp(16'h0700, 0, 0);
        rd();
        smp(16'h0100, 0, 0);
        check("R5 below holds none", source, 8'h00);
        smp(16'h0700, 0, 0);
        check("R6 saturated step back", source, 8'h42);
        rd();
        for (int i = 0; i < 5; i++) smp(16'h0100, 0, 0);
        smp(16'h0700, 0, 0); smp(16'h0700, 0, 0);
        check("R5 floor at zero", source, 8'h00);
        smp(16'h0700, 0, 0);
        check("R5 recount from zero", source, 8'h42);
        rd();
    endtask

    task automatic t_enable();
        start(8'h0A, 8'h05, 8'd0);
        smp(16'h7000, 16'h7000, 16'h7000);
        check("R7 Y only", source, 8'h48);
        @(negedge clk); axis_cfg = 8'h0C;
        smp(16'h7000, 16'h7000, 16'h7000);
        check("R7 Z added", source, 8'h68);
        rd();
    endtask

    task automatic t_live();
        start(8'h07, 8'h05, 8'd0);
        smp(16'h0600, 0, 0);
        check("R10 live hit", source, 8'h42);
        rd();
        check("R10 read keeps live", source, 8'h42);
        check("R11 read clears irq live", {7'b0, rate_irq}, 8'h00);
        smp(0, 0, 0);
        check("R10 follows sample", source, 8'h00);
        check("R11 no hit no irq", {7'b0, rate_irq}, 8'h00);
    endtask

    task automatic t_priority();
        start(8'h09, 8'h05, 8'd0);
        smp(16'h0600, 0, 0);
        smp(16'h0100, 0, 0);
        check("R9 latched holds", source, 8'h42);
        @(negedge clk);
        rate_x = 16'hF800; sample_stb = 1'b1; source_rd = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0; source_rd = 1'b0;
        check("R9 hit beats read", source, 8'h43);
        check("R11 hit beats read", {7'b0, rate_irq}, 8'h01);
        rd();
    endtask

    task automatic t_run_start();
        start(8'h09, 8'h85, 8'd3);
        for (int i = 0; i < 3; i++) smp(16'h0700, 0, 0);
        check("R12 pre", source, 8'h42);
        start(8'h09, 8'h85, 8'd3);
        check("R12 flags wiped", source, 8'h00);
        check("R12 irq wiped", {7'b0, rate_irq}, 8'h00);
        smp(16'h0700, 0, 0); smp(16'h0700, 0, 0);
        start(8'h09, 8'h85, 8'd3);
        smp(16'h0700, 0, 0); smp(16'h0700, 0, 0);
        check("R12 counter wiped", source, 8'h00);
        smp(16'h0700, 0, 0);
        check("R12 count after wipe", source, 8'h42);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_limit();
        t_clear_mode();
        t_dec_mode();
        t_enable();
        t_live();
        t_priority();
        t_run_start();
        summary();
    end

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end
endmodule